// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external 32K x 8 static RAM that has no clock of its own. The host presents a request with a direction flag, a 15-bit word address and a byte of write data. The controller then walks the memory's active-low chip select, write strobe and output strobe through a timed sequence. Each phase of that sequence lasts a whole number of clock cycles, and each of those counts is a parameter. To pick a count, take the memory's minimum or maximum time, divide it by the clock period and round up.

A write is ended by the write strobe, and the output strobe stays high for the whole write. The first phase is an address setup phase with the chip selected. The write strobe then falls. While it is low there are two sub-phases: first a float interval, where the controller keeps its driver off so the memory can release the pins, then a data-drive interval. After the write strobe rises, the data and the chip select are held for a short hold phase. A read applies the address, chip select and output strobe together for a fixed access window. The byte on the bus is captured on the last clock of that window and returned with a one-cycle valid pulse.

A busy flag covers the whole access. Requests that arrive while it is high are dropped. Between accesses every strobe is high and the data driver is off.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever busy is low, mem_ce_n, mem_we_n and mem_oe_n are all 1 (strobes are active low) and mem_dout_en is 0.
- R2: A request seen with busy low is accepted on that clock edge. Busy is high from the next cycle for exactly T_SETUP_CYC+T_WE_CYC+T_HOLD_CYC cycles on a write (req_wr=1) and T_RD_CYC cycles on a read (req_wr=0).
- R3: A request presented while busy is high starts no access: no extra chip-select pulse occurs and no memory location changes.
- R4: In a write, chip select is low for T_SETUP_CYC cycles before the write strobe falls. The write strobe stays low for exactly T_WE_CYC cycles. The output strobe stays high throughout, and chip select is low for T_SETUP_CYC+T_WE_CYC+T_HOLD_CYC cycles in total.
- R5: The data driver turns on only after the write strobe has been low for T_HIZ_CYC cycles. It stays on for T_HOLD_CYC cycles after the write strobe rises and turns off together with chip select.
- R6: In a read, chip select and the output strobe fall in the same cycle and stay low for exactly T_RD_CYC cycles. The write strobe stays high.
- R7: Read data is taken from mem_din on the last cycle of the read window and shown on rd_data, with rd_valid high for exactly one cycle. That cycle is the one in which busy returns low.
- R8: The write strobe is low only while chip select is low and the output strobe is high. The data driver is on only while chip select is low and the output strobe is high.
- R9: mem_addr does not change while chip select stays low.
- R10: A byte written to any address is returned by a later read of that address, until that address is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when busy is low |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of the access |
| req_wdata | input | DW | Byte to write |
| busy | output | 1 | High while an access is in progress |
| rd_valid | output | 1 | One-cycle pulse marking valid rd_data |
| rd_data | output | DW | Byte returned by the last read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Data toward the memory pins |
| mem_dout_en | output | 1 | Enable of the controller's data driver |
| mem_din | input | DW | Data read from the memory pins |

## Verification
The assertions assume two things: a reset at time zero, and a host that raises req only between clock edges and holds the address and data steady until the edge that accepts them. The bench drives every input on the falling edge and holds req for exactly one rising edge, so both assumptions hold. The only time it presents a request during busy is the deliberate R3 case, where the block must ignore it. The bench's memory model writes on the rising write strobe and drives the bus only when chip select and output strobe are low. Any overlap between that drive and the controller's driver is therefore caught at the pins.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WSETUP = 3'd1,
    PH_WFLOAT = 3'd2,
    PH_WDRIVE = 3'd3,
    PH_WHOLD  = 3'd4,
    PH_RWIN   = 3'd5
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } pins_t;

  localparam pins_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic pins_t pins_for(phase_e ph);
    pins_t p;
    p = PINS_QUIET;
    case (ph)
      PH_WSETUP: p.ce_n = 1'b0;
      PH_WFLOAT: begin p.ce_n = 1'b0; p.we_n = 1'b0; end
      PH_WDRIVE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
      PH_WHOLD:  begin p.ce_n = 1'b0; p.drv = 1'b1; end
      PH_RWIN:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      default:   p = PINS_QUIET;
    endcase
    return p;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int T_SETUP_CYC = 1,
  parameter int T_HIZ_CYC   = 1,
  parameter int T_WE_CYC    = 2,
  parameter int T_HOLD_CYC  = 1,
  parameter int T_RD_CYC    = 2,
  parameter int CW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          rd_done,
  output logic          busy,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          drv
);

  localparam logic [CW-1:0] LEN_SETUP = CW'(T_SETUP_CYC - 1);
  localparam logic [CW-1:0] LEN_FLOAT = CW'(T_HIZ_CYC - 1);
  localparam logic [CW-1:0] LEN_DRIVE = CW'(T_WE_CYC - T_HIZ_CYC - 1);
  localparam logic [CW-1:0] LEN_HOLD  = CW'(T_HOLD_CYC - 1);
  localparam logic [CW-1:0] LEN_RD    = CW'(T_RD_CYC - 1);

  phase_e ph_q, ph_d;
  pins_t  pins_q;
  logic   busy_q;

  // next-phase logic
  always_comb begin
    ph_d     = ph_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    rd_done  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_wr) begin
            ph_d    = PH_WSETUP;
            tmr_val = LEN_SETUP;
          end else begin
            ph_d    = PH_RWIN;
            tmr_val = LEN_RD;
          end
        end
      end
      PH_WSETUP: begin
        if (tmr_zero) begin
          ph_d     = PH_WFLOAT;
          tmr_load = 1'b1;
          tmr_val  = LEN_FLOAT;
        end
      end
      PH_WFLOAT: begin
        if (tmr_zero) begin
          ph_d     = PH_WDRIVE;
          tmr_load = 1'b1;
          tmr_val  = LEN_DRIVE;
        end
      end
      PH_WDRIVE: begin
        if (tmr_zero) begin
          ph_d     = PH_WHOLD;
          tmr_load = 1'b1;
          tmr_val  = LEN_HOLD;
        end
      end
      PH_WHOLD: begin
        if (tmr_zero) ph_d = PH_IDLE;
      end
      PH_RWIN: begin
        if (tmr_zero) begin
          ph_d    = PH_IDLE;
          rd_done = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // registers: pins come straight from flops so they never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      pins_q <= PINS_QUIET;
      busy_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pins_q <= pins_for(ph_d);
      busy_q <= (ph_d != PH_IDLE);
    end
  end

  assign busy = busy_q;
  assign ce_n = pins_q.ce_n;
  assign we_n = pins_q.we_n;
  assign oe_n = pins_q.oe_n;
  assign drv  = pins_q.drv;

  AST_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ce_n && we_n && oe_n && !drv)); // R1
  AST_WE_NEEDS_CE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n)); // R8
  AST_DRV_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> (!ce_n && oe_n)); // R8
  AST_DRV_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> (!we_n && $past(!we_n))); // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) && !ce_n) |-> drv); // R5
  AST_DRV_OFF_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv) |-> ce_n); // R5
  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n)); // R6
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy); // R2

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rd_done,
  input  logic [DW-1:0] mem_din,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);

  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;
  logic [DW-1:0] rdata_d;
  logic          cap_en;
  logic          smp_en;

  always_comb begin
    cap_en  = accept;
    smp_en  = rd_done;
    addr_d  = req_addr;
    wdata_d = req_wdata;
    rdata_d = mem_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (smp_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= smp_en;
  end

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |=> !rvalid_q); // R7

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int T_SETUP_CYC = 1,
  parameter int T_HIZ_CYC   = 1,
  parameter int T_WE_CYC    = 2,
  parameter int T_HOLD_CYC  = 1,
  parameter int T_RD_CYC    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);

  localparam int TMAX = max2(max2(T_SETUP_CYC, T_WE_CYC), max2(T_HOLD_CYC, T_RD_CYC));
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          accept;
  logic          rd_done;

  sram_ctl_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_ctl_seq #(
    .T_SETUP_CYC (T_SETUP_CYC),
    .T_HIZ_CYC   (T_HIZ_CYC),
    .T_WE_CYC    (T_WE_CYC),
    .T_HOLD_CYC  (T_HOLD_CYC),
    .T_RD_CYC    (T_RD_CYC),
    .CW          (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_wr   (req_wr),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .rd_done  (rd_done),
    .busy     (busy),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .drv      (mem_dout_en)
  );

  sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_done   (rd_done),
    .mem_din   (mem_din),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dout),
    .rdata_q   (rd_data),
    .rvalid_q  (rd_valid)
  );

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R9
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout)); // R5
  AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy))); // R7

endmodule

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam int TS = 2;
  localparam int TZ = 1;
  localparam int TW = 3;
  localparam int TH = 2;
  localparam int TR = 3;

  logic          clk;
  logic          rst_n;
  logic          req;
  logic          req_wr;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          busy;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          mem_ce_n;
  logic          mem_we_n;
  logic          mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic          mem_dout_en;
  logic [DW-1:0] mem_din;

  sram_ctl #(
    .AW(AW), .DW(DW), .T_SETUP_CYC(TS), .T_HIZ_CYC(TZ),
    .T_WE_CYC(TW), .T_HOLD_CYC(TH), .T_RD_CYC(TR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // behavioural memory: reads when selected with output strobe low,
  // writes on the rising write strobe
  logic [DW-1:0] mem [NW];
  logic          mem_drives;
  int            bad_setup = 0;

  assign mem_drives = !mem_ce_n && mem_we_n && !mem_oe_n;
  assign mem_din = mem_dout_en ? mem_dout : (mem_drives ? mem[mem_addr] : '0);

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      if (!mem_dout_en) bad_setup++;
      mem[mem_addr] = mem_dout;
    end
  end

  // pin monitor, sampled on the falling edge
  int ce_run, we_run, hold_run, oe_run;
  int last_ce, last_we, last_hold, last_oe, last_setup, last_float;
  int ce_falls, oe_low_total, illegal;
  logic p_ce, p_we, p_drv;

  always @(negedge clk) begin
    if (!rst_n) begin
      ce_run = 0; we_run = 0; hold_run = 0; oe_run = 0;
      last_ce = 0; last_we = 0; last_hold = 0; last_oe = 0;
      last_setup = 0; last_float = 0; ce_falls = 0; oe_low_total = 0;
      illegal = 0; p_ce = 1'b1; p_we = 1'b1; p_drv = 1'b0;
    end else begin
      if (!mem_ce_n) begin
        if (p_ce) ce_falls++;
        if (!mem_we_n && p_we) last_setup = ce_run;
        ce_run++;
      end else if (ce_run != 0) begin
        last_ce = ce_run; ce_run = 0;
      end
      if (!mem_we_n) begin
        if (mem_dout_en && !p_drv) last_float = we_run;
        we_run++;
      end else if (we_run != 0) begin
        last_we = we_run; we_run = 0;
      end
      if (mem_dout_en && mem_we_n) hold_run++;
      else if (hold_run != 0) begin last_hold = hold_run; hold_run = 0; end
      if (!mem_oe_n) begin oe_run++; oe_low_total++; end
      else if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end
      if (!mem_we_n && (mem_ce_n || !mem_oe_n)) illegal++;
      if (mem_dout_en && (mem_ce_n || !mem_oe_n)) illegal++;
      if (mem_dout_en && mem_drives) illegal++;
      p_ce = mem_ce_n; p_we = mem_we_n; p_drv = mem_dout_en;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + (a >> 3) + k * 91 + 5) ^ (k * 8'h5A));
  endfunction

  // issue one access, hold req for one rising edge, count busy cycles
  task automatic issue(input bit wr, input int a, input logic [DW-1:0] d, output int nbusy);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    nbusy = 0;
    while (busy && nbusy < 100) begin
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input bit full);
    int nb;
    int oe0;
    oe0 = oe_low_total;
    issue(1'b1, a, d, nb);
    if (full) check_eq("R2 write busy length", nb, TS + TW + TH);
    @(negedge clk); #1;
    if (full) begin
      check_eq("R4 write strobe width", last_we, TW);
      check_eq("R4 select before write strobe", last_setup, TS);
      check_eq("R4 select width on write", last_ce, TS + TW + TH);
      check_eq("R4 output strobe idle in write", oe_low_total - oe0, 0);
      check_eq("R5 float before drive", last_float, TZ);
      check_eq("R5 drive hold after strobe", last_hold, TH);
    end
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] exp, input bit full);
    int nb;
    issue(1'b0, a, '0, nb);
    if (full) check_eq("R2 read busy length", nb, TR);
    check_eq("R7 valid with busy fall", int'(rd_valid), 1);
    check_eq("R10 read data", int'(rd_data), int'(exp));
    @(negedge clk);
    if (full) check_eq("R7 valid single cycle", int'(rd_valid), 0);
    #1;
    if (full) begin
      check_eq("R6 output strobe width", last_oe, TR);
      check_eq("R6 select width on read", last_ce, TR);
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = '0;
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 ce_n at reset", int'(mem_ce_n), 1);
    check_eq("R1 we_n at reset", int'(mem_we_n), 1);
    check_eq("R1 oe_n at reset", int'(mem_oe_n), 1);
    check_eq("R1 driver at reset", int'(mem_dout_en), 0);
    check_eq("R1 busy at reset", int'(busy), 0);
    check_eq("R7 valid at reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // detailed single accesses
    do_write(5, 8'hA5, 1'b1);
    check_eq("R1 quiet after write", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}), 4'b1110);
    do_read(5, 8'hA5, 1'b1);
    check_eq("R1 quiet after read", int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}), 4'b1110);

    // R3: requests during busy are dropped
    begin
      int f0;
      do_write(9, 8'h3C, 1'b0);
      f0 = ce_falls;
      @(negedge clk);
      req = 1'b1; req_wr = 1'b1; req_addr = AW'(7); req_wdata = 8'h11;
      @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      req = 1'b1; req_wr = 1'b1; req_addr = AW'(9); req_wdata = 8'hEE;
      @(negedge clk);
      check_eq("R3 busy during access", int'(busy), 1);
      req_addr = AW'(9);
      req_wdata = 8'hEE;
      @(negedge clk);
      req = 1'b0;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      #1;
      // first request was accepted (address 7); the one during busy was not
      check_eq("R3 one select pulse", ce_falls - f0, 1);
      do_read(9, 8'h3C, 1'b0);
      do_read(7, 8'h11, 1'b0);
    end

    // exhaustive sweep of the small address space, two passes
    for (int k = 0; k < 2; k++) begin
      for (int a = 0; a < NW; a++) do_write(a, pat(a, k), (a == NW - 1));
      for (int a = 0; a < NW; a++) do_read(a, pat(a, k), (a == 0));
    end

    check_eq("R8 illegal strobe cycles", illegal, 0);
    check_eq("R5 data driven at write end", bad_setup, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule